// File: doc/BRIEF.md
# Multi-Level Sequential Trigger Unit

This block decides when an on-chip logic analyzer stops hunting and declares its capture trigger. On every rising edge of the sample clock it looks at a vector of probed signals, together with one external trigger input. It compares them against the condition stored for the trigger level it is currently waiting on. A chain of up to `MAX_LEVELS` levels must be met strictly one after another. When the last active level matches, the unit emits a single-cycle trigger pulse to other analyzers or equipment. It then holds a triggered state until software or a neighbouring controller re-arms it.

Each level stores a 3-bit condition per probe and a 2-bit condition for the external input. A level matches when every one of these terms is true in the same sample, so the terms are ANDed. Edge conditions compare the current sample with the sample taken one clock earlier. Configuration arrives through a one-cycle register-write port. The unit accepts it only while it is disarmed, so a running hunt never sees its conditions change underneath it.

Top module: `seq_trig_unit`

## Requirements
- R1: After reset the unit is disarmed. `trig_out`, `armed` and `triggered` are 0, `cur_level` is 0, the active level count is 1, and every level holds don't-care terms throughout. Arming straight after reset therefore fires on the first evaluated sample.
- R2: A probe condition field sits at `cfg_wdata[3*i+2:3*i]` for probe i. Its codes are: 0 always true, 1 probe low, 2 probe high, 3 rising (now 1, previous sample 0), 4 falling (now 0, previous sample 1). Codes 5 to 7 are never true. A level matches only when all its probe terms and its external term are true in the same sample.
- R3: The external term sits at `cfg_wdata[3*NUM_PROBES+1:3*NUM_PROBES]`. Its codes are: 0 ignore, 1 `ext_trig_in` high, 2 `ext_trig_in` low, 3 `ext_trig_in` rising against the previous sample.
- R4: While armed, only the level addressed by `cur_level` is evaluated. A match advances `cur_level` by exactly one on that edge, even if the same sample would satisfy later levels too. A sample that matches only some other level leaves `cur_level` unchanged.
- R5: A match of the level at index count-1 drives `trig_out` high for exactly the one cycle after that sample and sets `triggered`. No further pulse follows, whatever the probes do, until the unit is re-armed.
- R6: An `arm` pulse puts the unit in the armed state with `cur_level` 0, from either the disarmed or the triggered state. A `disarm` pulse returns the unit to the disarmed state. When both are high, `disarm` wins.
- R7: While disarmed, probe and external activity has no effect: `cur_level` holds its value and `trig_out` stays 0.
- R8: A write with `cfg_we` high is accepted only while the unit is disarmed. Address L below `MAX_LEVELS` loads the condition word of level L. Address `MAX_LEVELS` loads the active level count, where 0 becomes 1 and values above `MAX_LEVELS` become `MAX_LEVELS`. Higher addresses are ignored.
- R9: The previous-sample history used by edge terms is refreshed on every sample clock, armed or not. An input that was already high before arming does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| probe_in | input | NUM_PROBES | Probed signal vector |
| ext_trig_in | input | 1 | External trigger input, synchronous to clk |
| arm | input | 1 | Arm / re-arm pulse |
| disarm | input | 1 | Disarm pulse, overrides arm |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(MAX_LEVELS+1) | Level index, or MAX_LEVELS for the level count |
| cfg_wdata | input | 3*NUM_PROBES+2 | Condition word or level count |
| trig_out | output | 1 | One-cycle trigger pulse |
| armed | output | 1 | Unit is hunting for its level sequence |
| triggered | output | 1 | Final level has matched; waiting for re-arm |
| cur_level | output | max(1,$clog2(MAX_LEVELS)) | Index of the level being waited on |

## Verification
The bench sweeps all eight condition codes on every probe of a 4-probe build against all four previous/current value pairs. This separates level, edge and reserved codes and shows that edges are judged against the prior sample. An all-high pattern is driven with each of the sixteen probe vectors to show that the terms are ANDed. All external codes are swept against the four external value pairs in the same way. Sequencing is tried with probe patterns that satisfy a later level early, two levels at once, or nothing. This separates in-order, one-step advance from skipping. Count writes of 0, 15 and an out-of-range address, plus writes made while the unit is not disarmed, show clamping and the write lock through how many samples the hunt then takes.

// File: rtl/seq_trig_pkg.sv
// Package: seq_trig_pkg
// Shared encodings for the sequential trigger unit: per-probe condition
// codes, external-term codes and the sequencer state.
package seq_trig_pkg;

    // Per-probe condition codes (3 bits); 5..7 are reserved and never true.
    localparam logic [2:0] PC_ANY  = 3'd0;
    localparam logic [2:0] PC_LOW  = 3'd1;
    localparam logic [2:0] PC_HIGH = 3'd2;
    localparam logic [2:0] PC_RISE = 3'd3;
    localparam logic [2:0] PC_FALL = 3'd4;

    // External trigger term codes (2 bits).
    localparam logic [1:0] XC_IGNORE = 2'd0;
    localparam logic [1:0] XC_HIGH   = 2'd1;
    localparam logic [1:0] XC_LOW    = 2'd2;
    localparam logic [1:0] XC_RISE   = 2'd3;

    // Sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_FIRED = 2'd2
    } seq_state_t;

endpackage

// File: rtl/trig_cfg_regs.sv
// Module: trig_cfg_regs
// Holds the condition word of every trigger level and the active level
// count. Writes land only while wr_open is high (unit disarmed). The count
// is clamped to 1..MAX_LEVELS at write time. Addresses above MAX_LEVELS
// are dropped.
// Assumes: the write strobe is synchronous to clk and lasts one cycle per write.
module trig_cfg_regs #(
    parameter int NUM_PROBES = 8,
    parameter int MAX_LEVELS = 10
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             wr_open,
    input  logic [$clog2(MAX_LEVELS+1)-1:0]  wr_addr,
    input  logic [3*NUM_PROBES+1:0]          wr_data,
    output logic [MAX_LEVELS*(3*NUM_PROBES+2)-1:0] lvl_cfg_flat,
    output logic [$clog2(MAX_LEVELS+1)-1:0]  lvl_count
);

    localparam int CFG_W  = 3*NUM_PROBES + 2;
    localparam int CNT_W  = $clog2(MAX_LEVELS+1);

    logic wr_ok;

    // Gate every write with the disarmed condition.
    assign wr_ok = wr_en && wr_open;

    // One storage word per level, each with its own address decode.
    for (genvar g = 0; g < MAX_LEVELS; g++) begin : g_level
        logic [CFG_W-1:0] word_q;

        // Load this level's word when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_ok && (int'(wr_addr) == g)) begin
                word_q <= wr_data;
            end
        end

        assign lvl_cfg_flat[g*CFG_W +: CFG_W] = word_q;
    end

    // Active level count, clamped into the legal range on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_count <= CNT_W'(1);
        end else if (wr_ok && (int'(wr_addr) == MAX_LEVELS)) begin
            if (wr_data == '0) begin
                lvl_count <= CNT_W'(1);
            end else if (wr_data > CFG_W'(MAX_LEVELS)) begin
                lvl_count <= CNT_W'(MAX_LEVELS);
            end else begin
                lvl_count <= wr_data[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/trig_level_match.sv
// Module: trig_level_match
// Purely combinational. It evaluates one level's condition word against
// the current and previous samples of the probes and of the external input.
// The result is the AND of all terms.
// Assumes: the previous-sample inputs are the values from one clock earlier.
module trig_level_match
    import seq_trig_pkg::*;
#(
    parameter int NUM_PROBES = 8
) (
    input  logic [3*NUM_PROBES+1:0] cond,
    input  logic [NUM_PROBES-1:0]   probe_now,
    input  logic [NUM_PROBES-1:0]   probe_prev,
    input  logic                    ext_now,
    input  logic                    ext_prev,
    output logic                    hit
);

    logic [NUM_PROBES-1:0] bit_ok;
    logic                  ext_ok;
    logic [1:0]            ext_code;

    // One term evaluator per probe.
    for (genvar i = 0; i < NUM_PROBES; i++) begin : g_term
        logic [2:0] code;
        assign code = cond[3*i +: 3];

        // Decode this probe's condition against its two samples.
        always_comb begin
            case (code)
                PC_ANY:  bit_ok[i] = 1'b1;
                PC_LOW:  bit_ok[i] = !probe_now[i];
                PC_HIGH: bit_ok[i] = probe_now[i];
                PC_RISE: bit_ok[i] = probe_now[i] && !probe_prev[i];
                PC_FALL: bit_ok[i] = !probe_now[i] && probe_prev[i];
                default: bit_ok[i] = 1'b0;
            endcase
        end
    end

    assign ext_code = cond[3*NUM_PROBES +: 2];

    // Decode the external trigger term.
    always_comb begin
        case (ext_code)
            XC_IGNORE: ext_ok = 1'b1;
            XC_HIGH:   ext_ok = ext_now;
            XC_LOW:    ext_ok = !ext_now;
            default:   ext_ok = ext_now && !ext_prev;
        endcase
    end

    assign hit = (&bit_ok) && ext_ok;

endmodule

// File: rtl/trig_sequencer.sv
// Module: trig_sequencer
// Walks the level pointer through the active levels and owns the
// idle / hunt / fired state. It issues a one-cycle fire pulse when the last
// active level matches. Disarm overrides arm, and arm restarts at level 0.
// Assumes: lvl_count is in 1..MAX_LEVELS and stays still while hunting.
module trig_sequencer
    import seq_trig_pkg::*;
#(
    parameter int MAX_LEVELS = 10
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            arm,
    input  logic                                            disarm,
    input  logic                                            hit,
    input  logic [$clog2(MAX_LEVELS+1)-1:0]                 lvl_count,
    output seq_state_t                                      state,
    output logic [((MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1)-1:0] ptr,
    output logic                                            fire
);

    localparam int CNT_W = $clog2(MAX_LEVELS+1);

    logic at_last;

    // The pointer sits on the final active level.
    assign at_last = (CNT_W'(ptr) + CNT_W'(1)) == lvl_count;

    // State, pointer and trigger pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr   <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (disarm) begin
                state <= ST_IDLE;
            end else if (arm) begin
                state <= ST_HUNT;
                ptr   <= '0;
            end else if ((state == ST_HUNT) && hit) begin
                if (at_last) begin
                    state <= ST_FIRED;
                    fire  <= 1'b1;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/seq_trig_unit.sv
// Module: seq_trig_unit (top)
// Sequential multi-level trigger. It keeps a one-sample history of the probes
// and the external input, and selects the condition word of the current level.
// It feeds the match result to the sequencer, which produces the trigger pulse.
// Assumes: probe_in and ext_trig_in are synchronous to clk. The clock is
// never itself a probe.
module seq_trig_unit
    import seq_trig_pkg::*;
#(
    parameter int NUM_PROBES = 8,
    parameter int MAX_LEVELS = 10
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_PROBES-1:0]                  probe_in,
    input  logic                                   ext_trig_in,
    input  logic                                   arm,
    input  logic                                   disarm,
    input  logic                                   cfg_we,
    input  logic [$clog2(MAX_LEVELS+1)-1:0]        cfg_addr,
    input  logic [3*NUM_PROBES+1:0]                cfg_wdata,
    output logic                                   trig_out,
    output logic                                   armed,
    output logic                                   triggered,
    output logic [((MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1)-1:0] cur_level
);

    localparam int CFG_W = 3*NUM_PROBES + 2;
    localparam int CNT_W = $clog2(MAX_LEVELS+1);
    localparam int PTR_W = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1;

    logic [NUM_PROBES-1:0]       probe_prev;
    logic                        ext_prev;
    logic [MAX_LEVELS*CFG_W-1:0] lvl_cfg_flat;
    logic [CNT_W-1:0]            lvl_count;
    logic [CFG_W-1:0]            cur_cfg;
    logic [PTR_W-1:0]            ptr;
    logic                        hit;
    seq_state_t                  state;

    // Previous-sample history, refreshed every clock whatever the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_prev <= '0;
            ext_prev   <= 1'b0;
        end else begin
            probe_prev <= probe_in;
            ext_prev   <= ext_trig_in;
        end
    end

    trig_cfg_regs #(
        .NUM_PROBES (NUM_PROBES),
        .MAX_LEVELS (MAX_LEVELS)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_we),
        .wr_open      (state == ST_IDLE),
        .wr_addr      (cfg_addr),
        .wr_data      (cfg_wdata),
        .lvl_cfg_flat (lvl_cfg_flat),
        .lvl_count    (lvl_count)
    );

    // Pick the condition word of the level being waited on.
    assign cur_cfg = lvl_cfg_flat[int'(ptr)*CFG_W +: CFG_W];

    trig_level_match #(
        .NUM_PROBES (NUM_PROBES)
    ) u_match (
        .cond       (cur_cfg),
        .probe_now  (probe_in),
        .probe_prev (probe_prev),
        .ext_now    (ext_trig_in),
        .ext_prev   (ext_prev),
        .hit        (hit)
    );

    trig_sequencer #(
        .MAX_LEVELS (MAX_LEVELS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .disarm    (disarm),
        .hit       (hit),
        .lvl_count (lvl_count),
        .state     (state),
        .ptr       (ptr),
        .fire      (trig_out)
    );

    assign armed     = (state == ST_HUNT);
    assign triggered = (state == ST_FIRED);
    assign cur_level = ptr;

endmodule

// File: rtl/seq_trig_unit_chk.sv
// Module: seq_trig_unit_chk
// Property checker for seq_trig_unit, attached through bind below.
// Assumes: it is connected to the top's ports and to its level-count register.
module seq_trig_unit_chk #(
    parameter int MAX_LEVELS = 10
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   arm,
    input logic                                   disarm,
    input logic                                   trig_out,
    input logic                                   armed,
    input logic                                   triggered,
    input logic [((MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1)-1:0] cur_level,
    input logic [$clog2(MAX_LEVELS+1)-1:0]        lvl_count
);

    // R5: the trigger pulse never lasts two cycles.
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    // R5: a pulse always comes with the triggered state.
    p_pulse_with_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> triggered);

    // R4: while hunting, the pointer stays inside the active levels.
    p_ptr_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cur_level < lvl_count));

    // R4: an undisturbed hunt moves the pointer by at most one step.
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !arm && !disarm) |=>
            ((cur_level == $past(cur_level)) ||
             (cur_level == $past(cur_level) + 1'b1) || triggered));

    // R6: arm without disarm starts a hunt at level 0.
    p_arm_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !disarm) |=> (armed && (cur_level == '0)));

    // R6: disarm always ends in the disarmed state.
    p_disarm_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> (!armed && !triggered));

    // R7: no pulse can follow a sample taken while not hunting.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !trig_out);

    // R8: the level count cannot change unless the unit was disarmed.
    p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed || triggered) |=> $stable(lvl_count));

endmodule

bind seq_trig_unit seq_trig_unit_chk #(
    .MAX_LEVELS (MAX_LEVELS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .disarm    (disarm),
    .trig_out  (trig_out),
    .armed     (armed),
    .triggered (triggered),
    .cur_level (cur_level),
    .lvl_count (lvl_count)
);

// File: tb/seq_trig_unit_bench.sv
// Bench for seq_trig_unit on a 4-probe, 10-level build. It sweeps the condition
// codes exhaustively and walks the level sequencing, arming and configuration
// corners. Inputs change at the falling edge and outputs are read there.
module seq_trig_unit_bench;

    localparam int NP = 4;
    localparam int ML = 10;
    localparam int CW = 3*NP + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] probe_in = '0;
    logic          ext_trig_in = 1'b0;
    logic          arm = 1'b0;
    logic          disarm = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          trig_out;
    logic          armed;
    logic          triggered;
    logic [3:0]    cur_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    seq_trig_unit #(
        .NUM_PROBES (NP),
        .MAX_LEVELS (ML)
    ) u_seq_trig_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .probe_in    (probe_in),
        .ext_trig_in (ext_trig_in),
        .arm         (arm),
        .disarm      (disarm),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .trig_out    (trig_out),
        .armed       (armed),
        .triggered   (triggered),
        .cur_level   (cur_level)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(addr);
        cfg_wdata = CW'(data);
        step();
        cfg_we    = 1'b0;
    endtask

    task automatic do_arm();
        arm = 1'b1;
        step();
        arm = 1'b0;
    endtask

    task automatic do_disarm();
        disarm = 1'b1;
        step();
        disarm = 1'b0;
    endtask

    // One-level hunt: the previous sample is taken on the arm edge, the
    // current sample on the next edge; returns trig_out after that edge.
    task automatic one_shot(int word, logic [NP-1:0] pq, logic [NP-1:0] pn,
                            logic xq, logic xn, output logic res);
        do_disarm();
        wr(0, word);
        wr(ML, 1);
        probe_in = pq;
        ext_trig_in = xq;
        do_arm();
        probe_in = pn;
        ext_trig_in = xn;
        step();
        res = trig_out;
    endtask

    function automatic int exp_probe(int code, bit p, bit q);
        case (code)
            0: return 1;
            1: return int'(!p);
            2: return int'(p);
            3: return int'(p && !q);
            4: return int'(!p && q);
            default: return 0;
        endcase
    endfunction

    function automatic int exp_ext(int code, bit p, bit q);
        case (code)
            0: return 1;
            1: return int'(p);
            2: return int'(!p);
            default: return int'(p && !q);
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic r;
        @(negedge clk);
        step();
        step();
        // R1: reset state
        check("R1 armed", int'(armed), 0);
        check("R1 triggered", int'(triggered), 0);
        check("R1 trig_out", int'(trig_out), 0);
        check("R1 cur_level", int'(cur_level), 0);
        rst_n = 1'b1;
        step();
        probe_in = 4'b1010;
        do_arm();
        check("R6 armed after arm", int'(armed), 1);
        step();
        check("R1 default fires", int'(trig_out), 1);

        // R2, R9: every code on every probe, all sample pairs
        for (int b = 0; b < NP; b++) begin
            for (int c = 0; c < 8; c++) begin
                for (int v = 0; v < 4; v++) begin
                    logic [NP-1:0] pq, pn;
                    bit q = v[1];
                    bit p = v[0];
                    pq = {NP{~q}};
                    pn = {NP{p}} ^ 4'(c);
                    pq[b] = q;
                    pn[b] = p;
                    one_shot(c << (3*b), pq, pn, 1'b0, 1'b0, r);
                    check($sformatf("R2 probe%0d code%0d q%0d p%0d", b, c, q, p),
                          int'(r), exp_probe(c, p, q));
                end
            end
        end

        // R2: all-high on every probe is an AND across probes
        for (int v = 0; v < 16; v++) begin
            one_shot(14'h0092 | 14'h0400, 4'h0, 4'(v), 1'b0, 1'b0, r);
            check($sformatf("R2 and pattern %0d", v), int'(r), int'(v == 15));
        end

        // R3: external term codes
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 4; v++) begin
                one_shot(c << (3*NP), 4'h0, 4'h0, v[1], v[0], r);
                check($sformatf("R3 ext code%0d q%0d p%0d", c, v[1], v[0]),
                      int'(r), exp_ext(c, v[0], v[1]));
            end
        end
        ext_trig_in = 1'b0;

        // R9: a probe high before arming is not a rising edge
        do_disarm();
        wr(0, 3);
        wr(ML, 1);
        probe_in = 4'b0001;
        step();
        do_arm();
        step();
        check("R9 no edge from idle history", int'(trig_out), 0);

        // R4, R5: three-level sequence
        do_disarm();
        wr(0, 14'h002);
        wr(1, 14'h010);
        wr(2, 14'h080);
        wr(ML, 3);
        probe_in = 4'b0000;
        do_arm();
        check("R6 start level", int'(cur_level), 0);
        probe_in = 4'b0100;
        step();
        check("R4 later level early", int'(cur_level), 0);
        probe_in = 4'b0011;
        step();
        check("R4 single advance", int'(cur_level), 1);
        check("R4 no early pulse", int'(trig_out), 0);
        probe_in = 4'b0000;
        step();
        check("R4 hold on miss", int'(cur_level), 1);
        probe_in = 4'b0010;
        step();
        check("R4 second advance", int'(cur_level), 2);
        probe_in = 4'b0100;
        step();
        check("R5 pulse", int'(trig_out), 1);
        check("R5 triggered", int'(triggered), 1);
        step();
        check("R5 pulse width", int'(trig_out), 0);
        check("R5 triggered held", int'(triggered), 1);
        for (int k = 0; k < 6; k++) begin
            probe_in = 4'(k * 5);
            step();
            check("R5 no repeat pulse", int'(trig_out), 0);
        end

        // R8: count write while triggered is dropped
        wr(ML, 1);
        probe_in = 4'b0000;
        do_arm();
        check("R6 re-arm from triggered", int'(cur_level), 0);
        check("R6 re-armed", int'(armed), 1);
        probe_in = 4'b0001;
        step();
        check("R8 locked count level", int'(cur_level), 1);
        check("R8 locked count no pulse", int'(trig_out), 0);

        // R7: disarmed activity ignored
        probe_in = 4'b0010;
        disarm = 1'b1;
        step();
        disarm = 1'b0;
        check("R6 disarmed", int'(armed), 0);
        for (int k = 0; k < 6; k++) begin
            probe_in = (k % 2 == 0) ? 4'b0010 : 4'b0100;
            step();
            check("R7 level held", int'(cur_level), 1);
            check("R7 no pulse", int'(trig_out), 0);
        end

        // R6: disarm beats arm
        arm = 1'b1;
        disarm = 1'b1;
        step();
        arm = 1'b0;
        disarm = 1'b0;
        check("R6 disarm wins", int'(armed), 0);

        // R8: count 0 clamps to 1
        for (int l = 0; l < ML; l++) wr(l, 0);
        wr(ML, 0);
        do_arm();
        step();
        check("R8 zero count fires", int'(trig_out), 1);

        // R8: count 15 clamps to ML
        do_disarm();
        wr(ML, 15);
        do_arm();
        for (int k = 1; k < ML; k++) begin
            step();
            check("R8 clamp walk", int'(cur_level), k);
            check("R8 clamp no pulse", int'(trig_out), 0);
        end
        step();
        check("R8 clamp fires at max", int'(trig_out), 1);

        // R8: out-of-range address ignored
        do_disarm();
        wr(ML, 2);
        wr(ML + 1, 1);
        do_arm();
        step();
        check("R8 bad address level", int'(cur_level), 1);
        check("R8 bad address no pulse", int'(trig_out), 0);
        step();
        check("R8 bad address fires", int'(trig_out), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule